// File: doc/BRIEF.md
# Configuration command and status engine

This block is a small register-mapped command interface used by firmware to ask the platform for a shutdown or a reboot. Software writes a 32-bit command word into a control register; the engine masks two reserved bits, stores the result, decodes it at once against two fixed command codes and records the outcome in a two-bit status register. A shutdown or reboot command produces a single-cycle request pulse on its own output; any other command is recorded as an error. A separate data register holds a plain 32-bit payload for software.

The three registers exist only when the board type input carries the matching identifier. On any other board type their addresses act like unmapped space: reads return zero, writes change nothing, and the access is flagged as bad. Any address outside the three is also flagged as bad and reads zero. Reads are combinational from the stored state; writes take effect on the rising clock edge.

Top module: `cfg_cmd_engine`

## Requirements
- R1: After reset the data, control and status registers read zero and both request outputs are low.
- R2: The registers are reachable only when board_type_i equals 12'h190; otherwise reads of offsets 0xA0, 0xA4 and 0xA8 return zero and writes to them leave all state unchanged and raise no request.
- R3: Offset 0xA0 is a read/write data register that returns the last value written.
- R4: A write to the control register at offset 0xA4 stores the write data with bits 19:18 forced to zero, and a read returns that stored value.
- R5: Every control write sets status bit 0 (complete) on the same clock edge.
- R6: A stored command of 0xC0800000 (after masking) drives shutdown_req_o high for exactly the one cycle following the write edge, and leaves status at 2'b01.
- R7: A stored command of 0xC0900000 (after masking) drives reboot_req_o high for exactly the one cycle following the write edge, and leaves status at 2'b01.
- R8: Any other stored command sets status to 2'b11 (bit 1 = error) and raises no request.
- R9: A write to the status register at offset 0xA8 stores write data bits 1:0 only, so software can clear it.
- R10: bad_reg_o is high during a read or write whose address is not one of the three registers or whose board type does not match, and low during a valid access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| board_type_i | input | 12 | Board identifier; registers enabled when 12'h190 |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| bad_reg_o | output | 1 | Access targets an unmapped or disabled register |
| shutdown_req_o | output | 1 | One-cycle shutdown request |
| reboot_req_o | output | 1 | One-cycle reboot request |

## Verification
The hardest situations are writes that must change nothing: on a non-matching board the register state is invisible at the ports, so the bench loads known values first, switches the board type away, issues data and command writes, then switches back and reads the registers to show they kept their contents and that no request pulsed. A second corner is a command word that differs from a recognised code only in the reserved bits 19:18; the bench sends such a word and expects the request plus a masked read-back. Pulses are sampled in the cycle right after the write edge and again one cycle later to prove their single-cycle width.

// File: rtl/cfg_eng_pkg.sv
package cfg_eng_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned AW    = 8;
  localparam int unsigned BID_W = 12;
  localparam int unsigned SW    = 2;

  localparam logic [BID_W-1:0] BOARD_ID   = 12'h190;
  localparam logic [AW-1:0]    OFS_DATA   = 8'hA0;
  localparam logic [AW-1:0]    OFS_CTRL   = 8'hA4;
  localparam logic [AW-1:0]    OFS_STAT   = 8'hA8;
  localparam logic [DW-1:0]    CMD_MASK   = ~(32'h3 << 18);
  localparam logic [DW-1:0]    CMD_SHUT   = 32'hC080_0000;
  localparam logic [DW-1:0]    CMD_REBOOT = 32'hC090_0000;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_CTRL,
    SEL_STAT
  } reg_sel_e;
endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec
  import cfg_eng_pkg::*;
#(
  parameter logic [BID_W-1:0] BoardId = BOARD_ID
) (
  input  logic [BID_W-1:0] board_type_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  output reg_sel_e         sel_o,
  output logic             data_we_o,
  output logic             ctrl_we_o,
  output logic             stat_we_o,
  output logic             bad_o
);
  logic enabled;
  assign enabled = (board_type_i == BoardId);

  always_comb begin
    sel_o = SEL_NONE;
    if (enabled) begin
      unique case (addr_i)
        OFS_DATA: sel_o = SEL_DATA;
        OFS_CTRL: sel_o = SEL_CTRL;
        OFS_STAT: sel_o = SEL_STAT;
        default:  sel_o = SEL_NONE;
      endcase
    end
  end

  assign data_we_o = wr_en_i && (sel_o == SEL_DATA);
  assign ctrl_we_o = wr_en_i && (sel_o == SEL_CTRL);
  assign stat_we_o = wr_en_i && (sel_o == SEL_STAT);
  assign bad_o     = (rd_en_i || wr_en_i) && (sel_o == SEL_NONE);
endmodule

// File: rtl/cfg_cmd_dec.sv
module cfg_cmd_dec
  import cfg_eng_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_q_o,
  output logic          cmd_err_o,
  output logic          shutdown_o,
  output logic          reboot_o
);
  logic [DW-1:0] cmd_m;
  logic          hit_shut, hit_reboot;

  assign cmd_m      = wdata_i & CMD_MASK;
  assign hit_shut   = (cmd_m == CMD_SHUT);
  assign hit_reboot = (cmd_m == CMD_REBOOT);
  assign cmd_err_o  = !(hit_shut || hit_reboot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q_o   <= '0;
      shutdown_o <= 1'b0;
      reboot_o   <= 1'b0;
    end else begin
      if (ctrl_we_i) ctrl_q_o <= cmd_m;
      shutdown_o <= ctrl_we_i && hit_shut;
      reboot_o   <= ctrl_we_i && hit_reboot;
    end
  end

  assert_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (ctrl_q_o == ($past(wdata_i) & CMD_MASK)));

  assert_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({shutdown_o, reboot_o}));
endmodule

// File: rtl/cfg_stat_reg.sv
module cfg_stat_reg
  import cfg_eng_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic          cmd_err_i,
  input  logic          stat_we_i,
  input  logic [SW-1:0] wdata_i,
  output logic [SW-1:0] stat_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q_o <= '0;
    end else if (ctrl_we_i) begin
      stat_q_o <= {cmd_err_i, 1'b1};
    end else if (stat_we_i) begin
      stat_q_o <= wdata_i;
    end
  end

  assert_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> stat_q_o[0]);

  assert_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && cmd_err_i) |=> (stat_q_o == 2'b11));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i |=> (stat_q_o == $past(wdata_i)));
endmodule

// File: rtl/cfg_cmd_engine.sv
module cfg_cmd_engine
  import cfg_eng_pkg::*;
#(
  parameter logic [BID_W-1:0] BoardId = BOARD_ID
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BID_W-1:0] board_type_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             bad_reg_o,
  output logic             shutdown_req_o,
  output logic             reboot_req_o
);
  reg_sel_e      sel;
  logic          data_we, ctrl_we, stat_we, cmd_err;
  logic [DW-1:0] data_q, ctrl_q;
  logic [SW-1:0] stat_q;

  cfg_addr_dec #(.BoardId(BoardId)) u_dec (
    .board_type_i(board_type_i),
    .rd_en_i     (rd_en_i),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .sel_o       (sel),
    .data_we_o   (data_we),
    .ctrl_we_o   (ctrl_we),
    .stat_we_o   (stat_we),
    .bad_o       (bad_reg_o)
  );

  cfg_cmd_dec u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (ctrl_we),
    .wdata_i   (wdata_i),
    .ctrl_q_o  (ctrl_q),
    .cmd_err_o (cmd_err),
    .shutdown_o(shutdown_req_o),
    .reboot_o  (reboot_req_o)
  );

  cfg_stat_reg u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_we_i(ctrl_we),
    .cmd_err_i(cmd_err),
    .stat_we_i(stat_we),
    .wdata_i  (wdata_i[SW-1:0]),
    .stat_q_o (stat_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (data_we) data_q <= wdata_i;
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata_o = data_q;
      SEL_CTRL: rdata_o = ctrl_q;
      SEL_STAT: rdata_o = {{(DW-SW){1'b0}}, stat_q};
      default:  rdata_o = '0;
    endcase
  end

  // state frozen while the board type does not match
  assert_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (board_type_i != BoardId) |=> ($stable(data_q) && $stable(ctrl_q) && $stable(stat_q)
                                   && !shutdown_req_o && !reboot_req_o));

  assert_shut_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_req_o |-> (ctrl_q == CMD_SHUT && stat_q == 2'b01));

  assert_reboot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_req_o |-> (ctrl_q == CMD_REBOOT && stat_q == 2'b01));

  assert_badzero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && bad_reg_o) |-> (rdata_o == '0));
endmodule

// File: tb/cfg_cmd_engine_bench.sv
`timescale 1ns/1ps
module cfg_cmd_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] board = 12'h190;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        bad, shut, reb;

  int n_chk = 0, n_bad = 0;
  logic p1_shut, p1_reb, p2_shut, p2_reb, w_bad;

  always #2.5 clk = ~clk;

  cfg_cmd_engine u_cfg_cmd_engine (
    .clk_i(clk), .rst_ni(rst_n), .board_type_i(board),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .bad_reg_o(bad),
    .shutdown_req_o(shut), .reboot_req_o(reb)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    #1 w_bad = bad;
    @(posedge clk);
    #1 p1_shut = shut; p1_reb = reb;
    @(negedge clk);
    wr_en = 1'b0;
    @(posedge clk);
    #1 p2_shut = shut; p2_reb = reb;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d, output logic b);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata; b = bad;
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic b;
    check("R1 shutdown low", {31'b0, shut}, 0);
    check("R1 reboot low", {31'b0, reb}, 0);
    do_read(8'hA0, d, b); check("R1 data zero", d, 0);
    do_read(8'hA4, d, b); check("R1 ctrl zero", d, 0);
    do_read(8'hA8, d, b); check("R1 stat zero", d, 0);
    check("R10 valid read not bad", {31'b0, b}, 0);
  endtask

  task automatic t_data();
    logic [31:0] d; logic b;
    do_write(8'hA0, 32'h1234_5678);
    check("R10 valid write not bad", {31'b0, w_bad}, 0);
    do_read(8'hA0, d, b); check("R3 data readback", d, 32'h1234_5678);
    do_write(8'hA0, 32'hA5A5_0F0F);
    do_read(8'hA0, d, b); check("R3 data readback 2", d, 32'hA5A5_0F0F);
  endtask

  task automatic t_unknown_cmd();
    logic [31:0] d; logic b;
    do_write(8'hA4, 32'hFFFF_FFFF);
    check("R8 no shutdown", {31'b0, p1_shut}, 0);
    check("R8 no reboot", {31'b0, p1_reb}, 0);
    do_read(8'hA4, d, b); check("R4 masked readback", d, 32'hFFF3_FFFF);
    do_read(8'hA8, d, b); check("R8 status error", d, 32'h3);
    do_write(8'hA4, 32'hC0A0_0000);
    do_read(8'hA8, d, b); check("R8 near-code error", d, 32'h3);
  endtask

  task automatic t_status_clear();
    logic [31:0] d; logic b;
    do_write(8'hA8, 32'h0);
    do_read(8'hA8, d, b); check("R9 status cleared", d, 0);
    do_write(8'hA8, 32'hFFFF_FFFE);
    do_read(8'hA8, d, b); check("R9 only bits 1:0 kept", d, 32'h2);
    do_write(8'hA8, 32'h0);
  endtask

  task automatic t_shutdown(input logic [31:0] cmd, input string tag);
    logic [31:0] d; logic b;
    do_write(8'hA4, cmd);
    check({"R6 pulse ", tag}, {31'b0, p1_shut}, 1);
    check({"R6 no reboot ", tag}, {31'b0, p1_reb}, 0);
    check({"R6 pulse ends ", tag}, {31'b0, p2_shut}, 0);
    do_read(8'hA8, d, b); check({"R5 R6 status ", tag}, d, 32'h1);
    do_read(8'hA4, d, b); check({"R4 ctrl ", tag}, d, 32'hC080_0000);
  endtask

  task automatic t_reboot();
    logic [31:0] d; logic b;
    do_write(8'hA8, 32'h0);
    do_write(8'hA4, 32'hC090_0000);
    check("R7 pulse", {31'b0, p1_reb}, 1);
    check("R7 no shutdown", {31'b0, p1_shut}, 0);
    check("R7 pulse ends", {31'b0, p2_reb}, 0);
    do_read(8'hA8, d, b); check("R7 status", d, 32'h1);
  endtask

  task automatic t_wrong_board();
    logic [31:0] d; logic b;
    // preload known state
    do_write(8'hA0, 32'h0000_BEEF);
    do_write(8'hA4, 32'h0000_0001);
    do_write(8'hA8, 32'h0);
    board = 12'h140;
    do_read(8'hA0, d, b); check("R2 data reads zero", d, 0);
    check("R10 disabled read bad", {31'b0, b}, 1);
    do_read(8'hA4, d, b); check("R2 ctrl reads zero", d, 0);
    do_write(8'hA0, 32'hDEAD_0000);
    check("R10 disabled write bad", {31'b0, w_bad}, 1);
    do_write(8'hA4, 32'hC080_0000);
    check("R2 no shutdown", {31'b0, p1_shut}, 0);
    do_write(8'hA8, 32'h3);
    board = 12'h190;
    do_read(8'hA0, d, b); check("R2 data untouched", d, 32'h0000_BEEF);
    do_read(8'hA4, d, b); check("R2 ctrl untouched", d, 32'h0000_0001);
    do_read(8'hA8, d, b); check("R2 stat untouched", d, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d; logic b;
    do_read(8'h40, d, b);
    check("R10 unmapped bad", {31'b0, b}, 1);
    check("R10 unmapped reads zero", d, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_data();
    t_unknown_cmd();
    t_status_clear();
    t_shutdown(32'hC080_0000, "exact");
    do_write(8'hA8, 32'h0);
    t_shutdown(32'hC08C_0000, "reserved bits set");
    t_reboot();
    t_wrong_board();
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule